// File: doc/BRIEF.md
# Down-Counting Reload Timer with APB Register Access

This block is a timer peripheral that sits on an APB slave port inside a 4 KB address window. Software loads a start count and a reload count. While the run bit is set, the counter steps down by one on each count tick. When it steps from 1 to 0 it raises a sticky status flag, which drives the interrupt output, provided the interrupt enable is set. The counter stays at zero for one tick and then takes the reload count. Software clears the flag by writing a one to it.

The count tick comes from one of three sources. By default it is every PCLK cycle. It can also be gated by an external level, or taken from rising edges of an external signal. The external signal is resynchronised to PCLK before use. A fixed block of read-only identification bytes occupies the top of the window.

Top module: `apb_dcount_timer`

## Requirements
- R1: After reset, the control, current count, reload and status registers all read zero, and the interrupt output is low.
- R2: The control word at offset 0x000 keeps only four bits: bit 0 run, bit 1 external gate, bit 2 external clock, bit 3 interrupt enable. Bits 31:4 read as zero whatever was written.
- R3: With run set and neither external mode selected, the current count (offset 0x004) drops by one on every PCLK rising edge.
- R4: A tick taken at count 1 moves the counter to 0. The next tick loads the reload count (offset 0x008), so the counter holds zero for exactly one tick.
- R5: The status flag (offset 0x00C, bit 0) is set by the 1-to-0 step only when interrupt enable is 1. The interrupt output always equals the flag.
- R6: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it alone. When a 1-to-0 step and a clearing write fall in the same cycle, the flag stays set.
- R7: With a reload count of zero, a counter at zero stays at zero and no new interrupt is raised.
- R8: A write to the reload register also loads the same value into the current count.
- R9: In external gate mode, the counter holds while the synchronised external input is low and counts every PCLK cycle while it is high.
- R10: In external clock mode, the counter steps once per rising edge of the synchronised external input. When both mode bits are set, clock mode applies.
- R11: A write to the current count loads the written value and takes priority over a decrement or reload in the same cycle.
- R12: The byte registers at 0xFD0 to 0xFFC are read-only. In ascending address order they return 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R13: A read of any other offset returns zero. A write to an identification or unmapped offset changes nothing. PREADY is always 1 and PSLVERR always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and count clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not reading |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | External gate or count clock, asynchronous |
| timer_irq | output | 1 | Level interrupt, mirrors the status flag |

## Verification
The assertions assume that APB accesses follow the two-phase protocol: psel is set for a setup cycle before penable, and the address and data stay stable through the access. They also assume that ext_in, although asynchronous, is only ever seen through the synchroniser. The bench drives every bus signal on falling edges from one write task and one read task, each a fixed three-cycle access. It holds ext_in steady or toggles it slowly, with at least four PCLK cycles per level, so that every edge passes the synchroniser and tick counts can be worked out exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Word offsets (byte address bits 11:2) of the live registers
   localparam logic [9:0] W_CTRL   = 10'h000;
   localparam logic [9:0] W_COUNT  = 10'h001;
   localparam logic [9:0] W_RELOAD = 10'h002;
   localparam logic [9:0] W_STATUS = 10'h003;
   // Identification block: byte 0xFD0 .. 0xFFC
   localparam logic [9:0] W_ID_LO  = 10'h3F4;
   localparam logic [9:0] W_ID_HI  = 10'h3FF;
   localparam int         ID_COUNT = 12;

   typedef struct packed {
      logic irq_en;    // bit 3
      logic ext_clk;   // bit 2
      logic ext_gate;  // bit 1
      logic run;       // bit 0
   } ctrl_t;

   function automatic logic [7:0] id_byte(input logic [3:0] idx);
      logic [7:0] b;
      case (idx)
         4'd0:    b = 8'h04;
         4'd4:    b = 8'h22;
         4'd5:    b = 8'hB8;
         4'd6:    b = 8'h1B;
         4'd8:    b = 8'h0D;
         4'd9:    b = 8'hF0;
         4'd10:   b = 8'h05;
         4'd11:   b = 8'hB1;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_ext_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;

   // R10
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
   import tmr_pkg::*;
(
   input  ctrl_t ctrl_i,
   input  logic  ext_level_i,
   input  logic  ext_rise_i,
   output logic  tick_o
);
   // Clock mode has precedence over gate mode
   always_comb begin
      if (!ctrl_i.run)          tick_o = 1'b0;
      else if (ctrl_i.ext_clk)  tick_o = ext_rise_i;
      else if (ctrl_i.ext_gate) tick_o = ext_level_i;
      else                      tick_o = 1'b1;
   end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ld_count_i,
   input  logic             ld_reload_i,
   input  logic [CNT_W-1:0] ld_data_i,
   input  logic             irq_en_i,
   input  logic             sts_clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             sts_o
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q, rld_q;
   logic             sts_q;
   logic             ld_any, term;

   assign ld_any = ld_count_i | ld_reload_i;
   assign term   = tick_i & ~ld_any & (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= ZERO;
      else if (ld_any)
         cnt_q <= ld_data_i;
      else if (tick_i) begin
         if (cnt_q == ZERO) cnt_q <= rld_q;
         else               cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rld_q <= ZERO;
      else if (ld_reload_i) rld_q <= ld_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sts_q <= 1'b0;
      else if (term && irq_en_i) sts_q <= 1'b1;
      else if (sts_clr_i)        sts_q <= 1'b0;
   end

   assign count_o  = cnt_q;
   assign reload_o = rld_q;
   assign sts_o    = sts_q;

   // R4
   one_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_any && cnt_q == ONE) |=> (cnt_q == ZERO));
   // R4
   hold_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_any && cnt_q == ZERO) |=> (cnt_q == $past(rld_q)));
   // R5
   sts_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q) |-> $past(tick_i && irq_en_i && !ld_any && cnt_q == ONE));
   // R6
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr_i && !tick_i) |=> !sts_q);
   // R7
   zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rld_q == ZERO && cnt_q == ZERO && !ld_any) |=> (cnt_q == ZERO && !$rose(sts_q)));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ld_any) |=> $stable(cnt_q));
   // R11
   sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_count_i |=> (cnt_q == $past(ld_data_i)));

endmodule

// File: rtl/apb_dcount_timer.sv
module apb_dcount_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              ext_in,
   output logic              timer_irq
);
   localparam int DATA_W = 32;
   localparam int PAD_W  = DATA_W - CNT_W;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("apb_dcount_timer: CNT_W must lie in 2..32");
   end
   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("apb_dcount_timer: ADDR_W must cover a 4 KB window");
   end

   logic [9:0]       word;
   logic             wr_en, rd_en;
   ctrl_t            ctrl_q;
   logic             ext_lvl, ext_rise, tick;
   logic [CNT_W-1:0] cnt, rld;
   logic             sts;
   logic [DATA_W-1:0] cnt_ext, rld_ext;
   logic             unused_bits;

   assign word  = paddr[11:2];
   assign wr_en = psel & penable & pwrite;
   assign rd_en = psel & ~pwrite;
   assign unused_bits = ^{paddr, pwdata};

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)                      ctrl_q <= '0;
      else if (wr_en && word == W_CTRL)  ctrl_q <= ctrl_t'(pwdata[3:0]);
   end

   tmr_ext_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk     (pclk),
      .rst_n   (presetn),
      .async_i (ext_in),
      .level_o (ext_lvl),
      .rise_o  (ext_rise)
   );

   tmr_tick_sel tick_i (
      .ctrl_i      (ctrl_q),
      .ext_level_i (ext_lvl),
      .ext_rise_i  (ext_rise),
      .tick_o      (tick)
   );

   tmr_count_core #(.CNT_W(CNT_W)) core_i (
      .clk         (pclk),
      .rst_n       (presetn),
      .tick_i      (tick),
      .ld_count_i  (wr_en && word == W_COUNT),
      .ld_reload_i (wr_en && word == W_RELOAD),
      .ld_data_i   (pwdata[CNT_W-1:0]),
      .irq_en_i    (ctrl_q.irq_en),
      .sts_clr_i   (wr_en && word == W_STATUS && pwdata[0]),
      .count_o     (cnt),
      .reload_o    (rld),
      .sts_o       (sts)
   );

   if (PAD_W > 0) begin : g_pad
      assign cnt_ext = {{PAD_W{1'b0}}, cnt};
      assign rld_ext = {{PAD_W{1'b0}}, rld};
   end else begin : g_nopad
      assign cnt_ext = cnt;
      assign rld_ext = rld;
   end

   always_comb begin
      prdata = '0;
      if (rd_en) begin
         if (word >= W_ID_LO && word <= W_ID_HI)
            prdata = {24'h0, id_byte(4'(word - W_ID_LO))};
         else begin
            case (word)
               W_CTRL:   prdata = {28'h0, ctrl_q};
               W_COUNT:  prdata = cnt_ext;
               W_RELOAD: prdata = rld_ext;
               W_STATUS: prdata = {31'h0, sts};
               default:  prdata = '0;
            endcase
         end
      end
   end

   assign pready    = 1'b1;
   assign pslverr   = 1'b0;
   assign timer_irq = sts;

   // R2
   ctrl_keep_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_en && word != W_CTRL) |=> $stable(ctrl_q));
   // R5
   irq_follow_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (!ctrl_q.irq_en && !(wr_en && word == W_CTRL)) |=> !$rose(timer_irq));

endmodule

// File: tb/apb_dcount_timer_tb_top.sv
`timescale 1ns/1ps
module apb_dcount_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, ext_in = 1'b0, irq;
   int          n_tests = 0, n_fail = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   apb_dcount_timer dut_i (
      .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .timer_irq(irq)
   );

   localparam logic [11:0] A_CTRL = 12'h000, A_CNT = 12'h004,
                           A_RLD = 12'h008, A_STS = 12'h00C;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
      end
   endtask

   // write commits at the rising edge between the 2nd and 3rd falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge clk); penable = 1; #1 d = prdata;
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rd_chk("R1 ctrl", A_CTRL, 0);
      rd_chk("R1 count", A_CNT, 0);
      rd_chk("R1 reload", A_RLD, 0);
      rd_chk("R1 status", A_STS, 0);
      check("R1 irq", {31'h0, irq}, 0);
   endtask

   task automatic t_ctrl_bits;
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd_chk("R2 ctrl mask", A_CTRL, 32'h0000_000F);
      wr(A_CTRL, 0);
      rd_chk("R2 ctrl clear", A_CTRL, 0);
   endtask

   task automatic t_decrement;
      wr(A_CNT, 100);
      wr(A_CTRL, 1);
      idle(5);
      wr(A_CTRL, 0);              // 5 + 3 ticks
      rd_chk("R3 decrement", A_CNT, 92);
   endtask

   task automatic t_reload_loads;
      wr(A_RLD, 32'h55);
      rd_chk("R8 count loaded", A_CNT, 32'h55);
      rd_chk("R8 reload kept", A_RLD, 32'h55);
   endtask

   task automatic t_zero_hold;
      wr(A_RLD, 200);
      wr(A_CNT, 2);
      wr(A_CTRL, 9);
      wr(A_CTRL, 0);              // 2->1->0->200
      rd_chk("R4 hold then reload", A_CNT, 200);
      rd_chk("R5 status set", A_STS, 1);
      check("R5 irq mirrors", {31'h0, irq}, 1);
      wr(A_STS, 0);
      rd_chk("R6 write 0 keeps", A_STS, 1);
      wr(A_STS, 1);
      rd_chk("R6 w1c", A_STS, 0);
      check("R6 irq low", {31'h0, irq}, 0);
      wr(A_CNT, 3);
      wr(A_CTRL, 9);
      wr(A_CTRL, 0);              // 3->2->1->0
      rd_chk("R4 at zero", A_CNT, 0);
      wr(A_STS, 1);
   endtask

   task automatic t_no_irq_en;
      wr(A_RLD, 200);
      wr(A_CNT, 2);
      wr(A_CTRL, 1);
      wr(A_CTRL, 0);
      rd_chk("R5 no irq without enable", A_STS, 0);
      rd_chk("R5 counter reloaded", A_CNT, 200);
   endtask

   task automatic t_zero_reload;
      wr(A_RLD, 0);
      wr(A_CTRL, 9);
      idle(10);
      wr(A_CTRL, 0);
      rd_chk("R7 stays zero", A_CNT, 0);
      rd_chk("R7 no interrupt", A_STS, 0);
   endtask

   task automatic t_set_wins;
      wr(A_RLD, 1000);
      wr(A_CNT, 4);
      wr(A_CTRL, 9);
      idle(1);
      wr(A_STS, 1);               // lands on the 1->0 step
      wr(A_CTRL, 0);
      rd_chk("R6 set beats clear", A_STS, 1);
      wr(A_STS, 1);
      rd_chk("R6 cleared after", A_STS, 0);
   endtask

   task automatic t_sw_priority;
      wr(A_RLD, 1000);
      wr(A_CTRL, 1);
      wr(A_CNT, 50);
      wr(A_CTRL, 0);              // 3 ticks after load
      rd_chk("R11 write wins", A_CNT, 47);
   endtask

   task automatic t_gate;
      ext_in = 0; idle(5);
      wr(A_CNT, 100);
      wr(A_CTRL, 3);
      idle(10);
      wr(A_CTRL, 0);
      rd_chk("R9 gated low", A_CNT, 100);
      ext_in = 1; idle(5);
      wr(A_CTRL, 3);
      idle(5);
      wr(A_CTRL, 0);
      rd_chk("R9 gated high", A_CNT, 92);
      ext_in = 0; idle(5);
   endtask

   task automatic t_ext_clock;
      wr(A_CNT, 100);
      wr(A_CTRL, 5);
      for (int i = 0; i < 4; i++) begin
         ext_in = 1; idle(4);
         ext_in = 0; idle(4);
      end
      idle(6);
      wr(A_CTRL, 0);
      rd_chk("R10 four edges", A_CNT, 96);
      ext_in = 1; idle(5);
      wr(A_CNT, 100);
      wr(A_CTRL, 7);
      idle(10);
      wr(A_CTRL, 0);
      rd_chk("R10 clock mode wins", A_CNT, 100);
      ext_in = 0; idle(5);
   endtask

   task automatic t_ids;
      logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8,
                                   8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 12; i++)
         rd_chk($sformatf("R12 id %0d", i), 12'hFD0 + 12'(4 * i), {24'h0, exp_id[i]});
   endtask

   task automatic t_unmapped;
      wr(A_CTRL, 8);
      wr(A_RLD, 33);
      wr(12'hFD0, 32'hFF);
      rd_chk("R13 id read-only", 12'hFD0, 32'h04);
      wr(12'h020, 32'hFFFF_FFFF);
      rd_chk("R13 ctrl untouched", A_CTRL, 8);
      rd_chk("R13 reload untouched", A_RLD, 33);
      rd_chk("R13 unmapped read", 12'h010, 0);
      rd_chk("R13 unmapped high", 12'hFC0, 0);
      check("R13 pready", {31'h0, pready}, 1);
      check("R13 pslverr", {31'h0, pslverr}, 0);
      wr(A_CTRL, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_ctrl_bits();
      t_decrement();
      t_reload_loads();
      t_zero_hold();
      t_no_irq_en();
      t_zero_reload();
      t_set_wins();
      t_sw_priority();
      t_gate();
      t_ext_clock();
      t_ids();
      t_unmapped();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule